// File: doc/BRIEF.md
# Clock-Sampled Static RAM Core (8K x 8, Dual Chip Select)

This block is a synthesizable stand-in for an asynchronous 8K-word by 8-bit static RAM. A fast free-running clock samples the memory's control pins on every edge. The pins are an active-low select, an active-high select, an active-low write strobe and an active-low output strobe. The clock also samples a 13-bit address and an 8-bit input data bus. The bidirectional data pins of a real part appear here as three separate signals: an input byte, an output byte and an output drive enable. A pad wrapper can turn these into a tri-state bus.

The sampled control pins pick one of four modes: standby, outputs off, read and write. A write is not stored while the strobe is low. It is stored when the write finishes, meaning the first sample at which the write condition no longer holds. Any of three pins can end the write: the write strobe rising, the low-active select rising or the high-active select falling. The stored address and byte are those seen in the last sample before the write ended. In read mode the block drives the word at the sampled address. If that word is being stored in the same cycle, the new byte is forwarded to the output.

Top module: `sram_async_core`

## Requirements
- R1: The array holds 8,192 distinct bytes selected by a 13-bit address; the lowest, the highest and an interior address each keep their own value.
- R2: When `ce1_n` is 1 or `ce2` is 0 the block is in standby: `dout_en` is 0 whatever `we_n` and `oe_n` are, and a low `we_n` in standby stores nothing.
- R3: With `ce1_n`=0, `ce2`=1, `we_n`=1 and `oe_n`=1 the outputs are off (`dout_en`=0); in every cycle where `dout_en` is 0, `dout` is all zeros.
- R4: With `ce1_n`=0, `ce2`=1, `we_n`=1 and `oe_n`=0, `dout_en` is 1 and `dout` holds the stored byte at `addr`. Outputs reflect the pin values captured at the previous rising clock edge, so a new address shows one edge later.
- R5: With `ce1_n`=0, `ce2`=1 and `we_n`=0 the block is writing and `dout_en` is 0 for either value of `oe_n`.
- R6: A write ended by `we_n` returning to 1 stores the byte at its address.
- R7: A write ended by `ce1_n` returning to 1 stores the byte at its address.
- R8: A write ended by `ce2` returning to 0 stores the byte at its address.
- R9: If the address or data changes while a write stays active, only the values of the last active sample are stored, and the earlier addresses keep their old contents.
- R10: When a write ends because `we_n` rises while `oe_n` is 0 at the same address, the very first read cycle already shows the new byte.
- R11: While `rst_n` is 0, `dout_en` is 0. The release of reset stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce1_n | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| addr | input | 13 | Word address |
| din | input | 8 | Byte to be written |
| dout | output | 8 | Byte read out (zero when not driven) |
| dout_en | output | 1 | Data bus drive enable |

## Verification
The bench targets the three ways a write can end. A design that watched only the write strobe would lose the writes ended by either select. The bench moves the address and data during one long write, which exposes a design that stores the first sample, or every sample, instead of the last one. It holds the write strobe low in standby to catch a write decode that ignores the selects. It also reads the written word in the cycle the write ends: without forwarding, that read returns the stale byte.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUT_OFF = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

  typedef struct packed {
    logic sel_lo_n;   // active-low select
    logic sel_hi;     // active-high select
    logic wr_n;       // write strobe
    logic rd_n;       // output strobe
  } ctl_pins_t;

  localparam ctl_pins_t CTL_IDLE = '{sel_lo_n: 1'b1, sel_hi: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

  function automatic sram_mode_e decode_mode(input ctl_pins_t c);
    sram_mode_e m;
    if (c.sel_lo_n || !c.sel_hi) m = MODE_STANDBY;
    else if (!c.wr_n)            m = MODE_WRITE;
    else if (!c.rd_n)            m = MODE_READ;
    else                         m = MODE_OUT_OFF;
    return m;
  endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_async_pkg::*;
(
  input  ctl_pins_t ctl_i,
  output logic      wr_act_o,
  output logic      drive_en_o
);

  sram_mode_e mode;

  always_comb begin
    mode       = decode_mode(ctl_i);
    wr_act_o   = (mode == MODE_WRITE);
    drive_en_o = (mode == MODE_READ);
  end

endmodule

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
  import sram_async_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ctl_pins_t      ctl_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  din_i,
  input  logic           smp_wr_act_i,
  output ctl_pins_t      smp_ctl_o,
  output logic [AW-1:0]  smp_addr_o,
  output logic           hist_wr_act_o,
  output logic [AW-1:0]  hist_addr_o,
  output logic [DW-1:0]  hist_din_o
);

  ctl_pins_t     smp_ctl_q,  smp_ctl_d;
  logic [AW-1:0] smp_addr_q, smp_addr_d;
  logic [DW-1:0] smp_din_q,  smp_din_d;
  logic          hist_act_q, hist_act_d;
  logic [AW-1:0] hist_addr_q, hist_addr_d;
  logic [DW-1:0] hist_din_q,  hist_din_d;
  logic          hist_ld;

  // next-state
  always_comb begin
    smp_ctl_d   = ctl_i;
    smp_addr_d  = addr_i;
    smp_din_d   = din_i;
    hist_act_d  = smp_wr_act_i;
    // clock enable: capture address/data only while a write is active
    hist_ld     = smp_wr_act_i;
    hist_addr_d = hist_ld ? smp_addr_q : hist_addr_q;
    hist_din_d  = hist_ld ? smp_din_q  : hist_din_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_ctl_q   <= CTL_IDLE;
      smp_addr_q  <= '0;
      smp_din_q   <= '0;
      hist_act_q  <= 1'b0;
      hist_addr_q <= '0;
      hist_din_q  <= '0;
    end else begin
      smp_ctl_q   <= smp_ctl_d;
      smp_addr_q  <= smp_addr_d;
      smp_din_q   <= smp_din_d;
      hist_act_q  <= hist_act_d;
      hist_addr_q <= hist_addr_d;
      hist_din_q  <= hist_din_d;
    end
  end

  assign smp_ctl_o     = smp_ctl_q;
  assign smp_addr_o    = smp_addr_q;
  assign hist_wr_act_o = hist_act_q;
  assign hist_addr_o   = hist_addr_q;
  assign hist_din_o    = hist_din_q;

endmodule

// File: rtl/sram_write_end.sv
module sram_write_end (
  input  logic prev_wr_act_i,
  input  logic cur_wr_act_i,
  output logic commit_o
);

  // a write finishes on the first sample where the write condition is gone
  always_comb commit_o = prev_wr_act_i && !cur_wr_act_i;

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int AW     = 13,
  parameter int DW     = 8,
  parameter bit BYPASS = 1'b1
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] arr_rd;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[waddr_i] <= wdata_i;
  end

  always_comb arr_rd = mem[raddr_i];

  generate
    if (BYPASS) begin : g_fwd
      logic hit;
      always_comb begin
        hit     = wr_en_i && (waddr_i == raddr_i);
        rdata_o = hit ? wdata_i : arr_rd;
      end
    end else begin : g_nofwd
      always_comb rdata_o = arr_rd;
    end
  endgenerate

endmodule

// File: rtl/sram_async_core.sv
module sram_async_core
  import sram_async_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  ctl_pins_t     pin_ctl;
  ctl_pins_t     smp_ctl;
  logic [AW-1:0] smp_addr;
  logic          smp_wr_act;
  logic          smp_drive;
  logic          hist_wr_act;
  logic [AW-1:0] hist_addr;
  logic [DW-1:0] hist_din;
  logic          commit;
  logic [DW-1:0] rd_data;

  always_comb begin
    pin_ctl.sel_lo_n = ce1_n;
    pin_ctl.sel_hi   = ce2;
    pin_ctl.wr_n     = we_n;
    pin_ctl.rd_n     = oe_n;
  end

  sram_pin_sampler #(.AW(AW), .DW(DW)) u_sampler (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ctl_i        (pin_ctl),
    .addr_i       (addr),
    .din_i        (din),
    .smp_wr_act_i (smp_wr_act),
    .smp_ctl_o    (smp_ctl),
    .smp_addr_o   (smp_addr),
    .hist_wr_act_o(hist_wr_act),
    .hist_addr_o  (hist_addr),
    .hist_din_o   (hist_din)
  );

  sram_mode_decode u_decode (
    .ctl_i     (smp_ctl),
    .wr_act_o  (smp_wr_act),
    .drive_en_o(smp_drive)
  );

  sram_write_end u_wend (
    .prev_wr_act_i(hist_wr_act),
    .cur_wr_act_i (smp_wr_act),
    .commit_o     (commit)
  );

  sram_store #(.AW(AW), .DW(DW), .BYPASS(1'b1)) u_store (
    .clk    (clk),
    .wr_en_i(commit),
    .waddr_i(hist_addr),
    .wdata_i(hist_din),
    .raddr_i(smp_addr),
    .rdata_o(rd_data)
  );

  always_comb begin
    dout_en = smp_drive;
    dout    = smp_drive ? rd_data : '0;
  end

endmodule

// File: rtl/sram_async_core_chk.sv
module sram_async_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_sync_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          dout_en
);

  // R2
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    ($past(rst_sync_n) && ($past(ce1_n) || !$past(ce2))) |-> !dout_en);

  // R3
  outoff_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    ($past(rst_sync_n) && !$past(ce1_n) && $past(ce2) && $past(we_n) && $past(oe_n)) |-> !dout_en);

  // R4
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    ($past(rst_sync_n) && !$past(ce1_n) && $past(ce2) && $past(we_n) && !$past(oe_n)) |-> dout_en);

  // R5
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    ($past(rst_sync_n) && !$past(ce1_n) && $past(ce2) && !$past(we_n)) |-> !dout_en);

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !dout_en);

endmodule

bind sram_async_core sram_async_core_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_sync_n(rst_sync_n),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .dout      (dout),
  .dout_en   (dout_en)
);

// File: tb/sram_async_core_tb.sv
`timescale 1ns/1ps
module sram_async_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce1_n, ce2, we_n, oe_n;
  logic [12:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sram_async_core u_dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  typedef struct {
    logic       en;
    bit         known;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  model [int];
  logic        prev_act  = 1'b0;
  logic [12:0] prev_addr = '0;
  logic [7:0]  prev_din  = '0;

  // driver: apply pins at the falling edge and push the expected outcome
  task automatic drive(input logic c1n, input logic c2, input logic wn, input logic on,
                       input logic [12:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    logic act;
    @(negedge clk);
    ce1_n = c1n; ce2 = c2; we_n = wn; oe_n = on; addr = a; din = d;
    act = !c1n && c2 && !wn;
    if (prev_act && !act) model[int'(prev_addr)] = prev_din;
    if (act) begin prev_addr = a; prev_din = d; end
    prev_act = act;
    e.en    = !c1n && c2 && wn && !on;
    e.known = model.exists(int'(a));
    e.data  = e.known ? model[int'(a)] : 8'h00;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
    drive(1'b0, 1'b1, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [12:0] a, input string tag);
    drive(1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b1, 1'b1, 13'h0, 8'h00, "R2 idle");
  endtask

  // monitor: one edge after each drive, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (dout_en !== e.en) begin
          fails++;
          $display("FAIL %s: dout_en actual=%b expected=%b", e.tag, dout_en, e.en);
        end else if (e.en && e.known && dout !== e.data) begin
          fails++;
          $display("FAIL %s: dout actual=%02h expected=%02h", e.tag, dout, e.data);
        end else if (!e.en && dout !== 8'h00) begin
          fails++;
          $display("FAIL R3 (%s): undriven dout actual=%02h expected=00", e.tag, dout);
        end
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = '0; din = '0;
    // R11: reset state with read-mode pins applied
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      checks++;
      if (dout_en !== 1'b0) begin
        fails++;
        $display("FAIL R11: dout_en during reset actual=%b expected=0", dout_en);
      end
    end
    @(negedge clk);
    ce1_n = 1'b1; ce2 = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    rst_n = 1'b1;
    idle(4);

    // R6: write ended by the write strobe
    wr(13'h0005, 8'hA5, "R6 write");
    wr(13'h0005, 8'hA5, "R6 write");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 13'h0005, 8'h00, "R3 outputs off");
    rd(13'h0005, "R6 readback");

    // R7: write ended by the low-active select
    wr(13'h1FFF, 8'h3E, "R7 write");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 13'h1FFF, 8'h00, "R7 select1 end");
    idle(1);
    rd(13'h1FFF, "R7 readback");

    // R8: write ended by the high-active select
    wr(13'h0000, 8'hC1, "R8 write");
    wr(13'h0000, 8'hC1, "R8 write");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 13'h0000, 8'h00, "R8 select2 end");
    idle(1);
    rd(13'h0000, "R8 readback");

    // R1 / R4: distinct words, address change each cycle
    rd(13'h0005, "R1 interior");
    rd(13'h1FFF, "R1 top");
    rd(13'h0000, "R1 bottom");
    rd(13'h0005, "R4 address change");

    // R9: address and data move during one write
    wr(13'h000A, 8'h77, "R9 preload");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 13'h000A, 8'h00, "R9 preload end");
    wr(13'h000A, 8'h11, "R9 moving write");
    wr(13'h0014, 8'h22, "R9 moving write");
    wr(13'h0014, 8'h23, "R9 moving write");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 13'h0014, 8'h00, "R9 end");
    rd(13'h0014, "R9 last value stored");
    rd(13'h000A, "R9 earlier address untouched");

    // R10 / R5: end write straight into read of same word
    drive(1'b0, 1'b1, 1'b0, 1'b0, 13'h001E, 8'h3C, "R5 write with output strobe low");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 13'h001E, 8'h3C, "R5 write with output strobe low");
    rd(13'h001E, "R10 forwarded read");
    rd(13'h001E, "R10 stored read");

    // R2: standby ignores strobes, stores nothing
    drive(1'b1, 1'b1, 1'b0, 1'b0, 13'h0005, 8'hFF, "R2 select1 high");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 13'h0005, 8'hFF, "R2 select1 high");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 13'h0005, 8'hEE, "R2 select2 low");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 13'h0005, 8'hEE, "R2 select2 low");
    rd(13'h0005, "R2 no standby write");

    // R3: outputs off
    drive(1'b0, 1'b1, 1'b1, 1'b1, 13'h0005, 8'h00, "R3 outputs off");
    rd(13'h0014, "R4 read after off");
    idle(2);

    wait (sb.size() == 0);
    @(posedge clk); #1;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule